// File: doc/BRIEF.md
# Checkpoint Signature Reference Comparator

This block checks a running system against an earlier error-free run of the same deterministic workload. It does not compare two units every clock. Instead, at discrete checkpoints it samples a state description that arrives as a stream of data words. Between two checkpoint strobes, the accepted words are folded into one 32-bit signature. Only data words take part; address and control information never reaches the block.

A run starts with a pulse on `run_start`, and the mode chosen at that pulse holds for the whole run. In a record run, the signature of checkpoint *n* is written to entry *n* of an internal reference store. In a compare run, each closing signature is checked against the entry for the same checkpoint number. The first discrepancy raises a sticky error flag and latches that checkpoint number, which serves as the latency timestamp counted in checkpoints rather than clock cycles. A checkpoint that has no stored reference raises a sticky overflow flag instead. The same happens for a record checkpoint that finds the store full.

Top module: `ckpt_sig_cmp`

## Requirements
- R1: After reset, `err_flag`, `err_index` and `ovf_flag` are all 0, the checkpoint counter and the recorded count are 0, and the run mode is record.
- R2: The signature register starts at 0. Each cycle with `word_vld`=1 updates it as sig' = {sig[30:0], fb} XOR word, where fb is the XOR of sig bits 31, 21, 1 and 0. Cycles with `word_vld`=0 leave it unchanged.
- R3: A word accepted in the same cycle as `ckpt_stb` belongs to the checkpoint that this strobe closes. The register is then cleared, so a word in the cycle after the strobe belongs to the next checkpoint.
- R4: The run mode is sampled from `mode_rec` (1 = record, 0 = compare) only in a `run_start` cycle. Changing `mode_rec` later in a run has no effect on that run, and a compare run never alters the stored references.
- R5: In a record run, checkpoint *n* (counted from 0 at `run_start`) stores its signature at entry *n*. The recorded count becomes the number of checkpoints stored.
- R6: In a compare run, a checkpoint whose signature differs from its stored entry sets `err_flag` in the cycle after the strobe. `err_index` then shows that checkpoint number.
- R7: Only the first mismatching checkpoint is latched. `err_flag` and `err_index` hold until the next `run_start`.
- R8: `ovf_flag` is set, and no comparison is made, for a compare checkpoint whose number is at or beyond the recorded count. It is also set, with the signature dropped, for a record checkpoint beyond DEPTH (default 256). Once set, it holds until the next `run_start`.
- R9: `run_start` clears `err_flag`, `err_index`, `ovf_flag`, the checkpoint counter and the signature register. A word or strobe in the same cycle as `run_start` is ignored.
- R10: A compare run whose word stream reproduces the recorded signatures leaves `err_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_start | input | 1 | Begins a new run and samples `mode_rec` |
| mode_rec | input | 1 | Run mode at `run_start`: 1 record, 0 compare |
| word_vld | input | 1 | `word_data` carries a state word this cycle |
| word_data | input | 32 | State data word |
| ckpt_stb | input | 1 | Closes the current checkpoint |
| err_flag | output | 1 | Sticky mismatch indication |
| err_index | output | 8 | Checkpoint number of the first mismatch |
| ovf_flag | output | 1 | Sticky overflow: no reference, or store full |

## Verification
The two functions that can fall in the same cycle are word compaction and checkpoint closure: a data word may arrive together with the strobe that ends its checkpoint. The bench records a reference with a word in the strobe cycle. It then replays that word one cycle early, which must match, and one cycle late, which must mismatch at that checkpoint. The collision of `run_start` with a strobe and a word is provoked as well. It is judged by a following full compare run that must neither mismatch nor overflow.

// File: rtl/ckpt_pkg.sv
`timescale 1ns/1ps
// Package ckpt_pkg
// Shared constants for the checkpoint signature comparator.
// Assumes: the signature width and the compactor tap mask travel together.
package ckpt_pkg;
    localparam int unsigned SIG_W_DEF = 32;
    // feedback taps at bits 31, 21, 1 and 0
    localparam logic [SIG_W_DEF-1:0] TAPS_DEF = 32'h8020_0003;
    localparam int unsigned DEPTH_DEF = 256;
endpackage

// File: rtl/sig_misr.sv
`timescale 1ns/1ps
// Module sig_misr
// Compacts the accepted data words of one checkpoint into a signature.
// Assumes: a word arriving in the strobe cycle is part of the closing
// checkpoint; clear has priority and drops any word in its cycle.
module sig_misr #(
    parameter int unsigned SW = 32,
    parameter logic [SW-1:0] TAPS = 32'h8020_0003
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          vld,
    input  logic [SW-1:0] data,
    input  logic          stb,
    output logic [SW-1:0] sig_close
);
    logic [SW-1:0] sig_q;
    logic [SW-1:0] sig_step;
    logic          fb;

    // feedback bit and one compaction step
    always_comb begin
        fb       = ^(sig_q & TAPS);
        sig_step = vld ? ({sig_q[SW-2:0], fb} ^ data) : sig_q;
        sig_close = sig_step;
    end

    // signature register, restarted at every checkpoint and run start
    always_ff @(posedge clk) begin
        if (!rst_n)
            sig_q <= '0;
        else if (clear || stb)
            sig_q <= '0;
        else
            sig_q <= sig_step;
    end

    // R2: without a word, a strobe or a clear, the signature holds
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld && !stb && !clear) |=> $stable(sig_q));

    // R9: a run start leaves an empty signature
    a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sig_q == '0));
endmodule

// File: rtl/ref_store.sv
`timescale 1ns/1ps
// Module ref_store
// Holds one reference signature per checkpoint number.
// Assumes: one write port driven by the run controller, read combinationally
// at the current checkpoint number; contents are not reset.
module ref_store #(
    parameter int unsigned SW    = 32,
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [SW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [SW-1:0] rd_data
);
    logic [SW-1:0] mem [DEPTH];

    // write the closing signature of a record checkpoint
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    // present the reference for the current checkpoint
    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/run_ctrl.sv
`timescale 1ns/1ps
// Module run_ctrl
// Keeps the run mode, the checkpoint counter and the recorded count, and
// raises the sticky mismatch and overflow indications.
// Assumes: run_start has priority over a strobe in the same cycle; the
// recorded count survives compare runs and is reset only by a record run.
module run_ctrl #(
    parameter int unsigned SW    = 32,
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_start,
    input  logic          mode_rec,
    input  logic          ckpt_stb,
    input  logic [SW-1:0] sig_close,
    input  logic [SW-1:0] ref_sig,
    output logic          wr_en,
    output logic [AW-1:0] cur_idx,
    output logic          err_flag,
    output logic [AW-1:0] err_index,
    output logic          ovf_flag
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic          run_rec;
    logic [CW-1:0] idx_q;
    logic [CW-1:0] rec_cnt;
    logic          room;
    logic          have_ref;
    logic          differs;

    // decode the checkpoint situation for this cycle
    always_comb begin
        room     = idx_q < DEPTH_C;
        have_ref = idx_q < rec_cnt;
        differs  = sig_close != ref_sig;
        wr_en    = run_rec && ckpt_stb && !run_start && room;
        cur_idx  = idx_q[AW-1:0];
    end

    // run mode, counters and sticky indications
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_rec   <= 1'b1;
            idx_q     <= '0;
            rec_cnt   <= '0;
            err_flag  <= 1'b0;
            err_index <= '0;
            ovf_flag  <= 1'b0;
        end else if (run_start) begin
            run_rec   <= mode_rec;
            idx_q     <= '0;
            err_flag  <= 1'b0;
            err_index <= '0;
            ovf_flag  <= 1'b0;
            if (mode_rec)
                rec_cnt <= '0;
        end else if (ckpt_stb) begin
            if (run_rec) begin
                if (room) begin
                    idx_q   <= idx_q + 1'b1;
                    rec_cnt <= idx_q + 1'b1;
                end else begin
                    ovf_flag <= 1'b1;
                end
            end else begin
                if (have_ref) begin
                    idx_q <= idx_q + 1'b1;
                    if (differs && !err_flag) begin
                        err_flag  <= 1'b1;
                        err_index <= idx_q[AW-1:0];
                    end
                end else begin
                    ovf_flag <= 1'b1;
                end
            end
        end
    end

    // R7: the error indication stays until a new run
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !run_start) |=> err_flag);

    // R7: the latched checkpoint number does not move
    a_r7_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !run_start) |=> $stable(err_index));

    // R6: the error can only rise right after a strobe
    a_r6_rise_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !ckpt_stb |=> !$rose(err_flag));

    // R4: a record run never reports a mismatch
    a_r4_record_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (run_rec && !run_start) |=> !$rose(err_flag));

    // R8: overflow is sticky within a run
    a_r8_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !run_start) |=> ovf_flag);

    // R9: a new run starts with clean indications
    a_r9_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> (!err_flag && !ovf_flag));
endmodule

// File: rtl/ckpt_sig_cmp.sv
`timescale 1ns/1ps
// Module ckpt_sig_cmp
// Top of the checkpoint signature comparator: compactor, reference store
// and run controller.
// Assumes: word width equals signature width; DEPTH is a power of two.
module ckpt_sig_cmp
    import ckpt_pkg::*;
#(
    parameter int unsigned SW       = SIG_W_DEF,
    parameter logic [SW-1:0] TAPS   = TAPS_DEF,
    parameter int unsigned DEPTH    = DEPTH_DEF,
    localparam int unsigned AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_start,
    input  logic          mode_rec,
    input  logic          word_vld,
    input  logic [SW-1:0] word_data,
    input  logic          ckpt_stb,
    output logic          err_flag,
    output logic [AW-1:0] err_index,
    output logic          ovf_flag
);
    logic [SW-1:0] sig_close;
    logic [SW-1:0] ref_sig;
    logic          wr_en;
    logic [AW-1:0] cur_idx;

    sig_misr #(.SW(SW), .TAPS(TAPS)) u_misr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (run_start),
        .vld       (word_vld),
        .data      (word_data),
        .stb       (ckpt_stb),
        .sig_close (sig_close)
    );

    ref_store #(.SW(SW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (cur_idx),
        .wr_data (sig_close),
        .rd_idx  (cur_idx),
        .rd_data (ref_sig)
    );

    run_ctrl #(.SW(SW), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_start (run_start),
        .mode_rec  (mode_rec),
        .ckpt_stb  (ckpt_stb),
        .sig_close (sig_close),
        .ref_sig   (ref_sig),
        .wr_en     (wr_en),
        .cur_idx   (cur_idx),
        .err_flag  (err_flag),
        .err_index (err_index),
        .ovf_flag  (ovf_flag)
    );
endmodule

// File: tb/sim_ckpt_sig_cmp.sv
`timescale 1ns/1ps
module sim_ckpt_sig_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_start = 1'b0;
    logic        mode_rec = 1'b0;
    logic        word_vld = 1'b0;
    logic [31:0] word_data = '0;
    logic        ckpt_stb = 1'b0;
    logic        err_flag;
    logic [7:0]  err_index;
    logic        ovf_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [31:0] A0 = 32'h1234_5678;
    localparam logic [31:0] A1 = 32'hCAFE_0001;
    localparam logic [31:0] WB = 32'h0F0F_A5A5;
    localparam logic [31:0] WC = 32'h8000_0001;
    localparam logic [31:0] WD = 32'h0000_0040;

    always #4 clk = ~clk;

    ckpt_sig_cmp u0 (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .mode_rec(mode_rec),
        .word_vld(word_vld), .word_data(word_data), .ckpt_stb(ckpt_stb),
        .err_flag(err_flag), .err_index(err_index), .ovf_flag(ovf_flag)
    );

    // compaction step as stated in R2
    function automatic logic [31:0] mstep(logic [31:0] s, logic [31:0] w);
        logic f;
        f = s[31] ^ s[21] ^ s[1] ^ s[0];
        return {s[30:0], f} ^ w;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(bit st, bit md, bit v, logic [31:0] d, bit s);
        @(negedge clk);
        run_start = st; mode_rec = md; word_vld = v; word_data = d; ckpt_stb = s;
    endtask

    task automatic idle(bit md);
        drive(1'b0, md, 1'b0, 32'hDEAD_BEEF, 1'b0);
    endtask

    task automatic start(bit md);
        drive(1'b1, md, 1'b0, '0, 1'b0);
        idle(md);
    endtask

    // checkpoint strobe, then sample one clock later
    task automatic stb_chk(bit md, bit v, logic [31:0] d, int cp, int first);
        drive(1'b0, md, v, d, 1'b1);
        idle(md);
        chk($sformatf("R6 err after cp%0d", cp), 32'(err_flag), 32'(cp >= first));
        if (cp >= first)
            chk($sformatf("R7 index after cp%0d", cp), 32'(err_index), 32'(first));
    endtask

    // reference workload; bad: corrupted checkpoint, form: cp0/cp1 variant
    task automatic play(bit md, int bad, int form);
        int first;
        logic [31:0] s0;
        logic [31:0] wx;
        first = bad;
        if (form == 2 && first > 1) first = 1;
        // cp0
        if (form == 3) begin
            s0 = mstep(mstep('0, A0), A1);
            wx = 32'h5555_0F0F;
            drive(1'b0, md, 1'b1, wx, 1'b0);
            drive(1'b0, md, 1'b1, mstep(wx, '0) ^ s0, 1'b0);
        end else begin
            drive(1'b0, md, 1'b1, A0, 1'b0);
            drive(1'b0, md, 1'b0, 32'hFFFF_FFFF, 1'b0);
            drive(1'b0, md, 1'b1, (bad == 0) ? (A1 ^ 32'h1) : A1, 1'b0);
        end
        stb_chk(md, 1'b0, '0, 0, first);
        // cp1
        if (form == 1) begin
            drive(1'b0, md, 1'b1, (bad == 1) ? ~WB : WB, 1'b0);
            stb_chk(md, 1'b0, '0, 1, first);
        end else if (form == 2) begin
            stb_chk(md, 1'b0, '0, 1, first);
            drive(1'b0, md, 1'b1, WB, 1'b0);
        end else begin
            stb_chk(md, 1'b1, (bad == 1) ? ~WB : WB, 1, first);
        end
        // cp2
        drive(1'b0, md, 1'b1, (bad == 2) ? (WC ^ 32'h100) : WC, 1'b0);
        stb_chk(md, 1'b0, '0, 2, first);
        // cp3
        if (bad == 3) drive(1'b0, md, 1'b1, WD, 1'b0);
        stb_chk(md, 1'b0, '0, 3, first);
    endtask

    task automatic t_reset;
        chk("R1 err_flag", 32'(err_flag), 0);
        chk("R1 err_index", 32'(err_index), 0);
        chk("R1 ovf_flag", 32'(ovf_flag), 0);
    endtask

    task automatic t_record;
        start(1'b1);
        play(1'b1, 99, 0);
        chk("R5 record no ovf", 32'(ovf_flag), 0);
    endtask

    task automatic t_match;
        start(1'b0);
        play(1'b0, 99, 0);
        chk("R10 match no err", 32'(err_flag), 0);
        chk("R8 no ovf within count", 32'(ovf_flag), 0);
        stb_chk(1'b0, 1'b0, '0, 4, 99);
        chk("R8 ovf beyond count", 32'(ovf_flag), 1);
    endtask

    task automatic t_mismatch;
        start(1'b0);
        play(1'b0, 2, 0);
        chk("R7 first index kept", 32'(err_index), 2);
        start(1'b0);
        play(1'b0, 0, 0);
        chk("R6 index cp0", 32'(err_index), 0);
    endtask

    task automatic t_same_cycle;
        start(1'b0);
        play(1'b0, 99, 1);
        chk("R3 early word matches", 32'(err_flag), 0);
        start(1'b0);
        play(1'b0, 99, 2);
        chk("R3 late word mismatches", 32'(err_flag), 1);
        chk("R3 late word index", 32'(err_index), 1);
    endtask

    task automatic t_linear;
        start(1'b0);
        play(1'b0, 99, 3);
        chk("R2 equivalent stream matches", 32'(err_flag), 0);
    endtask

    task automatic t_mode_mid;
        start(1'b0);
        play(1'b1, 1, 0);
        chk("R4 mode change ignored", 32'(err_flag), 1);
        start(1'b0);
        play(1'b0, 99, 0);
        chk("R4 references intact", 32'(err_flag), 0);
    endtask

    task automatic t_start_collide;
        start(1'b0);
        play(1'b0, 3, 0);
        chk("R9 error present", 32'(err_flag), 1);
        drive(1'b1, 1'b0, 1'b1, 32'h7777_7777, 1'b1);
        idle(1'b0);
        chk("R9 err cleared", 32'(err_flag), 0);
        chk("R9 index cleared", 32'(err_index), 0);
        chk("R9 ovf cleared", 32'(ovf_flag), 0);
        play(1'b0, 99, 0);
        chk("R9 collide ignored no err", 32'(err_flag), 0);
        chk("R9 collide ignored no ovf", 32'(ovf_flag), 0);
    endtask

    task automatic t_depth;
        start(1'b1);
        for (int i = 0; i < 257; i++) begin
            drive(1'b0, 1'b1, 1'b0, '0, 1'b1);
            idle(1'b1);
            if (i == 255) chk("R8 record full no ovf", 32'(ovf_flag), 0);
            if (i == 256) chk("R8 record beyond depth ovf", 32'(ovf_flag), 1);
        end
        start(1'b0);
        for (int i = 0; i < 256; i++) begin
            drive(1'b0, 1'b0, 1'b0, '0, 1'b1);
            idle(1'b0);
        end
        chk("R8 full compare no ovf", 32'(ovf_flag), 0);
        chk("R10 full compare no err", 32'(err_flag), 0);
        drive(1'b0, 1'b0, 1'b0, '0, 1'b1);
        idle(1'b0);
        chk("R8 compare beyond depth", 32'(ovf_flag), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1'b0);
        t_reset();
        t_record();
        t_match();
        t_mismatch();
        t_same_cycle();
        t_linear();
        t_mode_mid();
        t_start_collide();
        t_depth();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule